// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers

This block moves data words from a producer on one clock to a consumer on a second clock that has no fixed relation to the first. The producer offers a word with a valid strobe and is held off by a full flag. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and takes it with a take strobe. Each side has its own synchronous, active-high reset.

Both pointers are counters one bit wider than the memory address, so every entry can be filled. Each pointer is kept as a Gray code that is built from a hidden binary count. Only one bit changes per step, so a capture in the other clock domain always sees either the old value or the new one. A chain of flip-flops in the destination domain (two by default) retimes each Gray pointer before it is compared. Full is evaluated only from write-domain registers and empty only from read-domain registers. Both flags release late and never early.

Top module: `dual_clock_fifo`

## Requirements
- R1: One clock edge with reset held in its domain leaves the write side with full low and the read side with empty high.
- R2: A word is stored only on a write-clock edge where valid is high and full is low. Words offered while full is high are dropped and never appear at the read port.
- R3: The read position moves only on a read-clock edge where take is high and empty is low. Take while empty has no effect, so the next word written is the next word read.
- R4: Words leave in the order they were accepted, with no loss or duplication. Each Gray pointer changes by at most one bit per edge of its own clock.
- R5: While empty is low, the read data output shows the oldest unread word combinationally. With take low it holds that word unchanged across read-clock edges.
- R6: With the reader idle after reset, exactly DEPTH words (8 by default) are accepted before full rises. Full rises on the edge that stores the last of them.
- R7: After a write into an empty FIFO, empty falls within three read-clock edges. After a read from a full FIFO, full falls within three write-clock edges (default two synchronizer stages).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_valid | input | 1 | Producer offers wr_data this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry seen from the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_take | input | 1 | Consumer takes the word on rd_data this cycle |
| rd_data | output | DATA_W | Oldest unread word, valid while rd_empty is low |
| rd_empty | output | 1 | No unread word seen from the read domain |

## Verification
The hardest situation to reach is the one where both pointers wrap repeatedly while a flag sits on its limit. In this state the inverted top bits of the full test and the synchronizer delay both matter at once. The two clocks run at periods of 8 ns and 14 ns, so their edges never coincide and their phase drifts. Random segments then alternate a fast writer against a slow reader and a slow writer against a fast reader. This makes the FIFO hover at full and at empty across many pointer wraps, while every word read is compared with a model queue. Directed phases fill the FIFO to capacity and keep offering words while it is full. They also take while it is empty and measure how many edges each flag needs to release.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

   // Smallest synchronizer depth accepted by the FIFO.
   localparam int unsigned MIN_SYNC_STAGES = 2;
   // Widest pointer the Gray helper handles.
   localparam int unsigned MAX_PTR_W = 32;

   typedef logic [MAX_PTR_W-1:0] ptr_word_t;

   // Binary to reflected Gray code: each bit XOR its upper neighbour.
   function automatic ptr_word_t bin_to_gray(input ptr_word_t b);
      return b ^ (b >> 1);
   endfunction

endpackage

// File: rtl/afifo_gray_ctr.sv
module afifo_gray_ctr
   import afifo_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [AW:0]   gray,
   output logic [AW-1:0] addr
);

   localparam int unsigned PW = AW + 1;

   // Hidden binary count runs one step ahead of the registered Gray value.
   logic [PW-1:0] bin_q;
   logic [PW-1:0] gray_q;
   logic [PW-1:0] gray_d;

   assign gray_d = PW'(bin_to_gray(ptr_word_t'(bin_q)));

   always_ff @(posedge clk) begin
      if (rst) begin
         bin_q  <= PW'(1);
         gray_q <= '0;
      end else if (en) begin
         bin_q  <= bin_q + PW'(1);
         gray_q <= gray_d;
      end
   end

   assign gray = gray_q;
   // Current position is one behind the look-ahead count.
   assign addr = bin_q[AW-1:0] - AW'(1);

endmodule

// File: rtl/afifo_sync.sv
module afifo_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg_q[s] <= '0;
            else     stg_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg_q[s] <= '0;
            else     stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned AW     = 3
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) store_q[wr_addr] <= wr_data;
   end

   // Unclocked read path: output follows the read address.
   assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
   import afifo_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned ADDR_BITS   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_rst,
   input  logic              rd_take,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty
);

   localparam int unsigned PW = ADDR_BITS + 1;
   // Top two pointer bits flipped: Gray image of "one lap ahead".
   localparam logic [PW-1:0] LAP_MASK = PW'(3) << (PW - 2);

   if (ADDR_BITS < 1) begin : g_bad_aw
      $error("ADDR_BITS must be at least 1");
   end
   if (DEPTH != (1 << ADDR_BITS)) begin : g_bad_depth
      $error("DEPTH must equal 2**ADDR_BITS");
   end
   if (PW > MAX_PTR_W) begin : g_bad_pw
      $error("pointer wider than the Gray helper supports");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("SYNC_STAGES below the minimum");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic                 wr_en;
   logic                 rd_en;
   logic [PW-1:0]        wr_gray;
   logic [PW-1:0]        rd_gray;
   logic [PW-1:0]        rd_gray_in_wr;
   logic [PW-1:0]        wr_gray_in_rd;
   logic [ADDR_BITS-1:0] wr_addr;
   logic [ADDR_BITS-1:0] rd_addr;

   assign wr_en = wr_valid & ~wr_full;
   assign rd_en = rd_take  & ~rd_empty;

   afifo_gray_ctr #(.AW(ADDR_BITS)) u_wr_ctr (
      .clk  (wr_clk),
      .rst  (wr_rst),
      .en   (wr_en),
      .gray (wr_gray),
      .addr (wr_addr)
   );

   afifo_gray_ctr #(.AW(ADDR_BITS)) u_rd_ctr (
      .clk  (rd_clk),
      .rst  (rd_rst),
      .en   (rd_en),
      .gray (rd_gray),
      .addr (rd_addr)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
      .clk (wr_clk),
      .rst (wr_rst),
      .d   (rd_gray),
      .q   (rd_gray_in_wr)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
      .clk (rd_clk),
      .rst (rd_rst),
      .d   (wr_gray),
      .q   (wr_gray_in_rd)
   );

   assign wr_full  = (wr_gray == (rd_gray_in_wr ^ LAP_MASK));
   assign rd_empty = (rd_gray == wr_gray_in_rd);

   afifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(ADDR_BITS)) u_mem (
      .wr_clk  (wr_clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
   parameter int unsigned PW = 4
) (
   input logic          wr_clk,
   input logic          wr_rst,
   input logic          wr_valid,
   input logic          wr_full,
   input logic          rd_clk,
   input logic          rd_rst,
   input logic          rd_take,
   input logic          rd_empty,
   input logic [PW-1:0] wr_gray,
   input logic [PW-1:0] rd_gray
);

   // R1
   wr_reset_chk: assert property (@(posedge wr_clk) wr_rst |=> !wr_full);

   // R1
   rd_reset_chk: assert property (@(posedge rd_clk) rd_rst |=> rd_empty);

   // R2
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_full |=> $stable(wr_gray));

   // R2
   write_moves_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
      (wr_valid && !wr_full) |=> !$stable(wr_gray));

   // R3
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_empty |=> $stable(rd_gray));

   // R3
   read_moves_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_take && !rd_empty) |=> !$stable(rd_gray));

   // R4
   wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
      1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

   // R4
   rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      1'b1 |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));

endmodule

bind dual_clock_fifo afifo_chk #(.PW(ADDR_BITS + 1)) u_afifo_chk (
   .wr_clk   (wr_clk),
   .wr_rst   (wr_rst),
   .wr_valid (wr_valid),
   .wr_full  (wr_full),
   .rd_clk   (rd_clk),
   .rd_rst   (rd_rst),
   .rd_take  (rd_take),
   .rd_empty (rd_empty),
   .wr_gray  (wr_gray),
   .rd_gray  (rd_gray)
);

// File: tb/test_dual_clock_fifo.sv
module test_dual_clock_fifo;

   localparam int DATA_W = 32;
   localparam int DEPTH  = 8;
   localparam int ABITS  = 3;

   logic              wr_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              wr_rst = 1'b1;
   logic              rd_rst = 1'b1;
   logic              wr_valid = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_full;
   logic              rd_take = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_empty;

   always #4 wr_clk = ~wr_clk;   // 125 MHz
   always #7 rd_clk = ~rd_clk;

   dual_clock_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_BITS(ABITS)) i_dual_clock_fifo (
      .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_valid (wr_valid), .wr_data (wr_data),
      .wr_full (wr_full), .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_take (rd_take),
      .rd_data (rd_data), .rd_empty (rd_empty)
   );

   int                n_chk  = 0;
   int                n_fail = 0;
   logic [DATA_W-1:0] model_q [$];
   bit                wr_done = 1'b0;
   bit                finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] pattern(input int i);
      return 32'hC0DE_0000 ^ (DATA_W'(i) * 32'h0101_0107);
   endfunction

   // Called at write edge + 1; returns at the next write edge + 1.
   task automatic wr_cycle(input bit v, input logic [DATA_W-1:0] d, output bit acc);
      wr_valid = v;
      wr_data  = d;
      acc      = v && !wr_full;
      if (acc) model_q.push_back(d);
      @(posedge wr_clk); #1;
      wr_valid = 1'b0;
   endtask

   // Called at read edge + 1; returns at the next read edge + 1.
   task automatic rd_cycle(input bit t, output bit got);
      logic [DATA_W-1:0] exp;
      rd_take = t;
      got     = t && !rd_empty;
      if (got) begin
         if (model_q.size() == 0) begin
            check(1'b0, "R3 read while model empty", rd_data, '0);
         end else begin
            exp = model_q.pop_front();
            check(rd_data == exp, "R4 order", rd_data, exp);
         end
      end
      @(posedge rd_clk); #1;
      rd_take = 1'b0;
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         report();
         $finish;
      end
   end

   initial begin
      bit acc;
      bit got;
      int n_acc;
      int n_got;
      logic [DATA_W-1:0] lone;
      void'($urandom(32'd4242));

      // Reset both domains
      repeat (3) @(posedge wr_clk);
      #1 wr_rst = 1'b0;
      repeat (3) @(posedge rd_clk);
      #1 rd_rst = 1'b0;
      check(wr_full == 1'b0, "R1 full after reset", DATA_W'(wr_full), '0);
      check(rd_empty == 1'b1, "R1 empty after reset", DATA_W'(rd_empty), 1);

      // Fill with reader idle, keep offering past capacity
      @(posedge wr_clk); #1;
      n_acc = 0;
      for (int i = 0; i < DEPTH + 4; i++) begin
         wr_cycle(1'b1, pattern(i), acc);
         if (acc) n_acc++;
         if (i == DEPTH - 1)
            check(wr_full == 1'b1, "R6 full on last storing edge", DATA_W'(wr_full), 1);
      end
      check(n_acc == DEPTH, "R6 words accepted", DATA_W'(n_acc), DATA_W'(DEPTH));
      check(wr_full == 1'b1, "R6 full held", DATA_W'(wr_full), 1);

      // Head visible without take
      repeat (3) @(posedge rd_clk); #1;
      check(rd_empty == 1'b0, "R7 empty released", DATA_W'(rd_empty), 0);
      check(rd_data == pattern(0), "R5 head shown", rd_data, pattern(0));
      repeat (2) @(posedge rd_clk); #1;
      check(rd_data == pattern(0), "R5 head held", rd_data, pattern(0));

      // One read from full: full must release within three write edges
      rd_cycle(1'b1, got);
      @(posedge rd_clk); #1;
      repeat (3) @(posedge wr_clk); #1;
      check(wr_full == 1'b0, "R7 full released", DATA_W'(wr_full), 0);

      // Drain: ignored writes must not show up (R2)
      @(posedge rd_clk); #1;
      n_got = 1;
      for (int i = 0; i < DEPTH + 3; i++) begin
         rd_cycle(1'b1, got);
         if (got) n_got++;
      end
      check(n_got == DEPTH, "R2 only stored words read", DATA_W'(n_got), DATA_W'(DEPTH));
      check(rd_empty == 1'b1, "R3 empty after drain", DATA_W'(rd_empty), 1);

      // Take while empty has no effect
      for (int i = 0; i < 4; i++) rd_cycle(1'b1, got);
      check(rd_empty == 1'b1, "R3 still empty", DATA_W'(rd_empty), 1);
      lone = 32'h5A5A_1234;
      @(posedge wr_clk); #1;
      wr_cycle(1'b1, lone, acc);
      repeat (3) @(posedge rd_clk); #1;
      check(rd_empty == 1'b0, "R7 empty released after one write", DATA_W'(rd_empty), 0);
      check(rd_data == lone, "R3 next written is next read", rd_data, lone);
      rd_cycle(1'b1, got);
      check(got == 1'b1, "R3 lone word taken", DATA_W'(got), 1);

      // Random phase: bursty writer against bursty reader
      fork
         begin
            int wp [3] = '{85, 25, 60};
            @(posedge wr_clk); #1;
            for (int s = 0; s < 3; s++)
               for (int c = 0; c < 400; c++)
                  wr_cycle($urandom_range(99) < wp[s], $urandom(), acc);
            wr_done = 1'b1;
         end
         begin
            int guard = 0;
            @(posedge rd_clk); #1;
            while (!(wr_done && model_q.size() == 0) && guard < 20000) begin
               rd_cycle($urandom_range(99) < ((guard / 300) % 2 == 0 ? 30 : 90), got);
               guard++;
            end
         end
      join

      check(model_q.size() == 0, "R4 every word delivered", DATA_W'(model_q.size()), 0);
      repeat (4) @(posedge rd_clk); #1;
      check(rd_empty == 1'b1, "R4 empty at end", DATA_W'(rd_empty), 1);
      repeat (4) @(posedge wr_clk); #1;
      check(wr_full == 1'b0, "R4 not full at end", DATA_W'(wr_full), 0);

      finished = 1'b1;
      report();
      $finish;
   end

endmodule